// File: doc/BRIEF.md
# Widening Lane Multiply-Accumulate Unit

This unit is an integer vector datapath that multiplies pairs of unsigned lanes and folds the double-width products into an accumulator vector. Each operation takes two 128-bit source vectors and one 128-bit accumulator vector. One 64-bit half of each source is chosen, and that half is cut into 8-, 16- or 32-bit lanes. Each lane of the first source is multiplied by the same lane of the second source. The product, kept at twice the lane width, is then added to or subtracted from the matching wide lane of the accumulator.

The unit has two pipeline stages: a registered multiply and then a registered accumulate. It accepts one operation per clock and returns each result two clocks later with a valid flag. The unsupported size code is reported on an error output, and the accumulator is then passed through unchanged. No flags, saturation or overflow indication are produced.

Top module: `wmac_unit`

## Requirements
- R1: `in_size` selects the source lane width: 0 gives 8-bit lanes (8 result lanes of 16 bits), 1 gives 16-bit lanes (4 result lanes of 32 bits), and 2 gives 32-bit lanes (2 result lanes of 64 bits). Source lane e sits at bits [e*w +: w] of the chosen half, and result lane e sits at bits [e*2w +: 2w].
- R2: Source lanes are unsigned and zero-extended. Result lane e depends only on source lane e of each operand and on accumulator lane e.
- R3: With `in_upper` = 0 the lanes come from bits 63:0 of both sources. With `in_upper` = 1 they come from bits 127:64. The half that is not selected has no effect on the result.
- R4: With `in_sub` = 0 each product is added to its accumulator lane. With `in_sub` = 1 it is subtracted from the accumulator lane.
- R5: The add or subtract wraps modulo 2^(2w) inside each result lane, and no carry or borrow crosses into a neighbouring lane.
- R6: Size code 3 drives `out_illegal` high together with the result, and `out_result` equals the accumulator input of that operation.
- R7: `out_valid` is high exactly two clocks after a cycle in which `in_valid` was high. Operations issued on consecutive cycles each produce their own result on consecutive cycles.
- R8: Synchronous active-high reset clears both pipeline valid flags, so `out_valid` and `out_illegal` are low in the cycle after a reset edge.
- R9: For size codes 0, 1 and 2, `out_illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_size | input | 2 | Source lane width code (0: 8, 1: 16, 2: 32, 3: reserved) |
| in_upper | input | 1 | Half select: 0 takes bits 63:0, 1 takes bits 127:64 |
| in_sub | input | 1 | 1 subtracts the product, 0 adds it |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result valid, two clocks after the strobe |
| out_result | output | 128 | Accumulated result vector |
| out_illegal | output | 1 | Reserved size code was used |

## Verification
The bench builds the unit with the package defaults: a 128-bit vector, a 64-bit selectable half, and all three lane widths generated side by side. At this width every size code has more than one lane. Lane isolation and per-lane wraparound can therefore be seen at the port with all-ones operands, and the back-to-back stream covers both halves and both accumulate directions under every lane width.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

    localparam int VEC_W     = 128;
    localparam int HALF_W    = VEC_W / 2;
    localparam int NUM_SIZES = 3;
    localparam int BASE_W    = 8;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_RSV = 2'd3
    } lane_size_e;

    typedef struct packed {
        logic               valid;
        lane_size_e         size;
        logic               sub;
        logic [VEC_W-1:0]   prod;
        logic [VEC_W-1:0]   acc;
    } mul_stage_t;

    typedef struct packed {
        logic               valid;
        logic               illegal;
        logic [VEC_W-1:0]   result;
    } acc_stage_t;

    function automatic logic size_legal(lane_size_e s);
        return s != SZ_RSV;
    endfunction

endpackage

// File: rtl/wmac_mul.sv
module wmac_mul
    import wmac_pkg::*;
(
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             upper,
    input  lane_size_e       size,
    output logic [VEC_W-1:0] prod
);
    logic [HALF_W-1:0] half_a;
    logic [HALF_W-1:0] half_b;
    logic [VEC_W-1:0]  prod_v [NUM_SIZES];

    assign half_a = upper ? src_a[VEC_W-1:HALF_W] : src_a[HALF_W-1:0];
    assign half_b = upper ? src_b[VEC_W-1:HALF_W] : src_b[HALF_W-1:0];

    for (genvar v = 0; v < NUM_SIZES; v++) begin : g_width
        localparam int ES    = BASE_W << v;
        localparam int LANES = HALF_W / ES;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [2*ES-1:0] op_a;
            logic [2*ES-1:0] op_b;
            assign op_a = {{ES{1'b0}}, half_a[l*ES +: ES]};
            assign op_b = {{ES{1'b0}}, half_b[l*ES +: ES]};
            assign prod_v[v][l*2*ES +: 2*ES] = op_a * op_b;
        end
    end

    always_comb begin
        case (size)
            SZ_8:    prod = prod_v[0];
            SZ_16:   prod = prod_v[1];
            SZ_32:   prod = prod_v[2];
            default: prod = '0;
        endcase
    end
endmodule

// File: rtl/wmac_acc.sv
module wmac_acc
    import wmac_pkg::*;
(
    input  logic [VEC_W-1:0] prod,
    input  logic [VEC_W-1:0] acc,
    input  lane_size_e       size,
    input  logic             sub,
    output logic [VEC_W-1:0] result,
    output logic             illegal
);
    logic [VEC_W-1:0] res_v [NUM_SIZES];

    for (genvar v = 0; v < NUM_SIZES; v++) begin : g_width
        localparam int WW    = 2 * (BASE_W << v);
        localparam int LANES = VEC_W / WW;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [WW-1:0] a_l;
            logic [WW-1:0] p_l;
            assign a_l = acc[l*WW +: WW];
            assign p_l = prod[l*WW +: WW];
            assign res_v[v][l*WW +: WW] = sub ? (a_l - p_l) : (a_l + p_l);
        end
    end

    assign illegal = !size_legal(size);

    always_comb begin
        case (size)
            SZ_8:    result = res_v[0];
            SZ_16:   result = res_v[1];
            SZ_32:   result = res_v[2];
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
    import wmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_size,
    input  logic             in_upper,
    input  logic             in_sub,
    input  logic [127:0]     src_a,
    input  logic [127:0]     src_b,
    input  logic [127:0]     acc_in,
    output logic             out_valid,
    output logic [127:0]     out_result,
    output logic             out_illegal
);
    lane_size_e       size_in;
    logic [VEC_W-1:0] prod_c;
    logic [VEC_W-1:0] res_c;
    logic             ill_c;
    mul_stage_t       s1;
    acc_stage_t       s2;

    assign size_in = lane_size_e'(in_size);

    wmac_mul i_mul (
        .src_a (src_a),
        .src_b (src_b),
        .upper (in_upper),
        .size  (size_in),
        .prod  (prod_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1.valid <= 1'b0;
        end else begin
            s1.valid <= in_valid;
        end
        if (in_valid) begin
            s1.size <= size_in;
            s1.sub  <= in_sub;
            s1.prod <= prod_c;
            s1.acc  <= acc_in;
        end
    end

    wmac_acc i_acc (
        .prod    (s1.prod),
        .acc     (s1.acc),
        .size    (s1.size),
        .sub     (s1.sub),
        .result  (res_c),
        .illegal (ill_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2.valid   <= 1'b0;
            s2.illegal <= 1'b0;
        end else begin
            s2.valid   <= s1.valid;
            s2.illegal <= s1.valid & ill_c;
        end
        if (s1.valid) begin
            s2.result <= res_c;
        end
    end

    assign out_valid   = s2.valid;
    assign out_result  = s2.result;
    assign out_illegal = s2.illegal;
endmodule

// File: rtl/wmac_unit_checker.sv
module wmac_unit_checker (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   in_size,
    input logic [127:0] acc_in,
    input logic         out_valid,
    input logic [127:0] out_result,
    input logic         out_illegal
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_passthrough_R6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && out_valid && out_illegal) |-> (out_result == $past(acc_in, 2)));

    assert_legal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && out_valid && $past(in_size, 2) != 2'd3) |-> !out_illegal);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal));

    assert_illegal_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);
endmodule

bind wmac_unit wmac_unit_checker i_chk (.*);

// File: tb/test_wmac_unit.sv
module test_wmac_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   in_size;
    logic         in_upper;
    logic         in_sub;
    logic [127:0] src_a, src_b, acc_in;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_illegal;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wmac_unit i_wmac_unit (.*);

    localparam int N = 12;
    localparam logic [127:0] TA [N] = '{
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h1111_2222_3333_4444_5555_6666_7777_8888,
        128'h1111_2222_3333_4444_5555_6666_7777_8888,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hFFFF_FFFF_FFFF_FFFF_0000_0001_8000_0000,
        128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_1234_5678,
        128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_1234_5678,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0000_0000_0000_0001_0000_0000_0000_0002};
    localparam logic [127:0] TB [N] = '{
        128'h0F0F_0F0F_0F0F_0F0F_F0F0_F0F0_F0F0_F0F0,
        128'h0F0F_0F0F_0F0F_0F0F_F0F0_F0F0_F0F0_F0F0,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0002_0003_0004_0005_0006_0007_0008_0009,
        128'h0002_0003_0004_0005_0006_0007_0008_0009,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0000_0002,
        128'h0000_0003_0000_0005_0000_0007_0000_0009,
        128'h0000_0003_0000_0005_0000_0007_0000_0009,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0000_0000_0000_0003_0000_0000_0000_0004};
    localparam logic [127:0] TC [N] = '{
        128'h0,
        128'h1000_2000_3000_4000_5000_6000_7000_8000,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0,
        128'h0000_0001_0000_0002_0000_0003_0000_0004,
        128'h0,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0,
        128'h1111_1111_1111_1111_2222_2222_2222_2222,
        128'h0,
        128'hA5A5_A5A5_5A5A_5A5A_A5A5_A5A5_5A5A_5A5A,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF};
    localparam logic [1:0] TS [N]  = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1,
                                       2'd1, 2'd2, 2'd2, 2'd2, 2'd3, 2'd2};
    localparam logic       TU [N]  = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                       1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic       TSB [N] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
                                       1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    function automatic logic [127:0] ref_mac(logic [127:0] a, logic [127:0] b,
            logic [127:0] c, logic [1:0] sz, logic up, logic sb);
        logic [127:0] res;
        logic [63:0]  ha, hb, em, wm, x, y, p, cl, r;
        int es, nl;
        if (sz == 2'd3) return c;
        es = 8 << sz;
        nl = 64 / es;
        ha = up ? a[127:64] : a[63:0];
        hb = up ? b[127:64] : b[63:0];
        em = (64'd1 << es) - 64'd1;
        wm = (es == 32) ? '1 : ((64'd1 << (2 * es)) - 64'd1);
        res = '0;
        for (int e = 0; e < nl; e++) begin
            x  = (ha >> (e * es)) & em;
            y  = (hb >> (e * es)) & em;
            p  = x * y;
            cl = 64'(c >> (e * 2 * es)) & wm;
            r  = (sb ? (cl - p) : (cl + p)) & wm;
            res = res | (128'(r) << (e * 2 * es));
        end
        return res;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [1:0] sz, logic up, logic sb,
                         logic [127:0] a, logic [127:0] b, logic [127:0] c);
        in_valid = v; in_size = sz; in_upper = up; in_sub = sb;
        src_a = a; src_b = b; acc_in = c;
    endtask

    task automatic run_one(logic [1:0] sz, logic up, logic sb,
                           logic [127:0] a, logic [127:0] b, logic [127:0] c);
        @(negedge clk); drive(1'b1, sz, up, sb, a, b, c);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid after reset", 128'(out_valid), 128'd0);
        check("R8 illegal after reset", 128'(out_illegal), 128'd0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R7: back-to-back stream through the table
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R7 valid latency", 128'(out_valid), 128'd1);
                check("R1 R2 R3 R4 R5 lane result", out_result,
                      ref_mac(TA[i-2], TB[i-2], TC[i-2], TS[i-2], TU[i-2], TSB[i-2]));
                check(TS[i-2] == 2'd3 ? "R6 illegal flag" : "R9 legal flag",
                      128'(out_illegal), 128'(TS[i-2] == 2'd3));
            end else begin
                check("R7 no early valid", 128'(out_valid), 128'd0);
            end
            if (i < N) drive(1'b1, TS[i], TU[i], TSB[i], TA[i], TB[i], TC[i]);
            else       in_valid = 1'b0;
        end
        @(negedge clk);
        check("R7 valid drops", 128'(out_valid), 128'd0);

        // R5: 8-bit all-ones product 0xFE01 stays in its 16-bit lane
        run_one(2'd0, 1'b0, 1'b0, 128'hFF, 128'hFF, 128'h0);
        check("R5 lane product", out_result, 128'hFE01);

        // R4 R5: subtract 1*1 from zero wraps each 32-bit lane to all ones
        run_one(2'd1, 1'b0, 1'b1, 128'h0001_0001_0001_0001,
                128'h0001_0001_0001_0001, 128'h0);
        check("R4 R5 subtract wrap", out_result, {4{32'hFFFF_FFFF}});

        // R3 R5: upper half, 32-bit all ones plus all-ones accumulator
        run_one(2'd2, 1'b1, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
                {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, '1);
        check("R3 R5 upper wrap", out_result, {2{64'hFFFF_FFFE_0000_0000}});

        // R3: unselected (upper) half has no effect
        run_one(2'd1, 1'b0, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0003_0000_0000_0002},
                {64'hFFFF_FFFF_FFFF_FFFF, 64'h0005_0000_0000_0007}, '0);
        check("R3 lower half only", out_result, {32'd15, 32'd0, 32'd0, 32'd14});

        // R6: reserved code passes accumulator through
        run_one(2'd3, 1'b0, 1'b0, '1, '1, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677);
        check("R6 passthrough", out_result, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677);
        check("R6 illegal set", 128'(out_illegal), 128'd1);

        // R8: reset mid-flight drops queued valids
        @(negedge clk); drive(1'b1, 2'd3, 1'b0, 1'b0, '0, '0, '0);
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); rst = 1'b0;
        check("R8 flushed valid", 128'(out_valid), 128'd0);
        check("R8 flushed illegal", 128'(out_illegal), 128'd0);
        @(negedge clk);
        check("R8 stays idle", 128'(out_valid), 128'd0);

        finish_run();
    end
endmodule